// File: doc/BRIEF.md
# Control-Word Register Datapath

This block is the execution half of a small 16-bit processor. It holds eight 16-bit registers and a function unit. One packed 16-bit control word, presented every cycle, steers the whole block. The word names two source registers and a destination register. It selects the operand for the second bus, the operation, and the value written back, and it says whether a write happens at all. A sequencer outside the block produces the words. Instruction fetch and decoding happen outside the block.

The first bus reads a register and appears at the address output. The second bus carries either a register or an external constant and appears at the data output. The function unit combines the two buses and raises four status flags: overflow, carry, negative and zero. The write-back bus carries either the function result or external input data. It lands in the destination register on the rising clock edge when writing is enabled.

Top module: `cw_datapath`

## Requirements
- R1: The control word fields sit at fixed bit positions: destination select in [15:13], A-source select in [12:10], B-source select in [9:7], B-operand select in [6], operation code in [5:2], write-back source in [1] and write enable in [0].
- R2: `addr_out` always equals the register named by the A-source select, with no clock delay.
- R3: When bit [6] is 0, `data_out` equals the register named by the B-source select. When bit [6] is 1, `data_out` equals `const_in`.
- R4: The eight arithmetic operation codes are defined as follows:
  - 0000: A
  - 0001: A+1
  - 0010: A+B
  - 0011: A+B+1
  - 0100: A+~B
  - 0101: A-B
  - 0110: A-1
  - 0111: A

  Each result is taken modulo 2^16. The carry flag is the 17th bit of A + Y + c_in, where Y is the second addend and c_in is bit 0 of the code. The overflow flag is set when the signed sum leaves the range -32768 to 32767.
- R5: Operation codes 1000, 1001, 1010 and 1011 give A AND B, A OR B, A XOR B and NOT A.
- R6: Operation codes 1100, 1101 and 1110 give B, B shifted right by one and B shifted left by one, with a zero shifted in. Code 1111 gives B.
- R7: Negative is bit 15 of the result and zero is set when the result is 0. Carry and overflow are 0 for every code with bit [5] set.
- R8: When bit [1] is 0 the value written back is the function result. When it is 1 the value written back is `data_in`.
- R9: When bit [0] is 1, the write-back value enters the destination register on the rising edge. When bit [0] is 0, no register changes.
- R10: A read of the register being written returns its old value until the clock edge.
- R11: Reset clears all eight registers to zero.
- R12: Control word 0x2995 computes R1 <- R2 - R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ctrl_word | input | 16 | Packed control word |
| const_in | input | 16 | External constant for the B operand |
| data_in | input | 16 | External data for write-back |
| addr_out | output | 16 | A-bus value |
| data_out | output | 16 | B-bus value |
| flag_v | output | 1 | Signed overflow |
| flag_c | output | 1 | Carry out |
| flag_n | output | 1 | Result negative |
| flag_z | output | 1 | Result zero |

## Verification
The register contents are the only stored state. A corrupted register shows up at `addr_out` or `data_out` in the same cycle the control word selects it. It also shows up in the flags of every operation that reads it. A misrouted or missing write appears one cycle after the edge, as soon as the destination register is read back. For this reason, each write-back is followed at once by a read of the destination, and every register is read through both buses under all sixteen operation codes.

// File: rtl/dp_pkg.sv
package dp_pkg;
  localparam int unsigned DP_W  = 16;
  localparam int unsigned DP_AW = 3;

  typedef struct packed {
    logic [DP_AW-1:0] dst_sel;
    logic [DP_AW-1:0] a_sel;
    logic [DP_AW-1:0] b_sel;
    logic             b_const;
    logic [3:0]       op;
    logic             wb_ext;
    logic             wr_en;
  } ctrl_t;

  typedef enum logic [1:0] {
    LOG_AND = 2'b00,
    LOG_OR  = 2'b01,
    LOG_XOR = 2'b10,
    LOG_NOT = 2'b11
  } log_op_e;

  typedef enum logic [1:0] {
    SH_PASS  = 2'b00,
    SH_RIGHT = 2'b01,
    SH_LEFT  = 2'b10,
    SH_PASS2 = 2'b11
  } sh_op_e;
endpackage

// File: rtl/dp_rst_sync.sv
module dp_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/dp_regfile.sv
module dp_regfile #(
  parameter int unsigned W     = 16,
  parameter int unsigned NREG  = 8,
  localparam int unsigned AW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b
);
  logic [W-1:0] reg_q [NREG];
  logic [NREG-1:0] reg_en;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    assign reg_en[g] = we && (wa == AW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         reg_q[g] <= '0;
      else if (reg_en[g]) reg_q[g] <= wd;
    end
  end

  assign rd_a = reg_q[ra_a];
  assign rd_b = reg_q[ra_b];
endmodule

// File: rtl/dp_func.sv
module dp_func
  import dp_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   op,
  output logic [W-1:0] f,
  output logic         v,
  output logic         c,
  output logic         n,
  output logic         z
);
  logic [W-1:0] addend;
  logic [W:0]   sum;
  logic [W-1:0] log_res;
  logic [W-1:0] sh_res;

  always_comb begin
    unique case (op[2:1])
      2'b00:   addend = '0;
      2'b01:   addend = b;
      2'b10:   addend = ~b;
      default: addend = '1;
    endcase
    sum = {1'b0, a} + {1'b0, addend} + {{W{1'b0}}, op[0]};
  end

  always_comb begin
    unique case (log_op_e'(op[1:0]))
      LOG_AND: log_res = a & b;
      LOG_OR:  log_res = a | b;
      LOG_XOR: log_res = a ^ b;
      default: log_res = ~a;
    endcase
  end

  always_comb begin
    unique case (sh_op_e'(op[1:0]))
      SH_RIGHT: sh_res = {1'b0, b[W-1:1]};
      SH_LEFT:  sh_res = {b[W-2:0], 1'b0};
      default:  sh_res = b;
    endcase
  end

  always_comb begin
    if (!op[3]) begin
      f = sum[W-1:0];
      c = sum[W];
      v = (a[W-1] == addend[W-1]) && (sum[W-1] != a[W-1]);
    end else begin
      f = op[2] ? sh_res : log_res;
      c = 1'b0;
      v = 1'b0;
    end
    n = f[W-1];
    z = (f == '0);
  end
endmodule

// File: rtl/cw_datapath.sv
module cw_datapath
  import dp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] ctrl_word,
  input  logic [15:0] const_in,
  input  logic [15:0] data_in,
  output logic [15:0] addr_out,
  output logic [15:0] data_out,
  output logic        flag_v,
  output logic        flag_c,
  output logic        flag_n,
  output logic        flag_z
);
  localparam int unsigned NREG = 1 << DP_AW;

  ctrl_t          cw;
  logic           rst_n_s;
  logic [DP_W-1:0] bus_a, reg_b, bus_b, bus_f, bus_d;

  assign cw = ctrl_t'(ctrl_word);

  dp_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  dp_regfile #(.W(DP_W), .NREG(NREG)) u_rf (
    .clk   (clk),
    .rst_n (rst_n_s),
    .we    (cw.wr_en),
    .wa    (cw.dst_sel),
    .wd    (bus_d),
    .ra_a  (cw.a_sel),
    .ra_b  (cw.b_sel),
    .rd_a  (bus_a),
    .rd_b  (reg_b)
  );

  assign bus_b = cw.b_const ? const_in : reg_b;

  dp_func #(.W(DP_W)) u_fu (
    .a  (bus_a),
    .b  (bus_b),
    .op (cw.op),
    .f  (bus_f),
    .v  (flag_v),
    .c  (flag_c),
    .n  (flag_n),
    .z  (flag_z)
  );

  assign bus_d    = cw.wb_ext ? data_in : bus_f;
  assign addr_out = bus_a;
  assign data_out = bus_b;
endmodule

// File: rtl/cw_datapath_chk.sv
module cw_datapath_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] ctrl_word,
  input logic [15:0] const_in,
  input logic [15:0] data_in,
  input logic [15:0] addr_out,
  input logic [15:0] data_out,
  input logic        flag_v,
  input logic        flag_c,
  input logic        flag_n,
  input logic        flag_z
);
  logic [2:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         seen <= '0;
    else if (!seen[2])  seen <= seen + 3'd1;
  end

  AST_CONST_ON_B: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[6] |-> data_out == const_in); // R3

  AST_PASS_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[5:2] == 4'b0000 |-> !flag_c && !flag_v && (flag_z == (addr_out == 16'h0))); // R4

  AST_SHIFT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word[5:2] == 4'b1100 && ctrl_word[6])
      |-> flag_n == const_in[15] && flag_z == (const_in == 16'h0) && !flag_c && !flag_v); // R7

  AST_EXT_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n || !seen[2])
    (ctrl_word[0] && ctrl_word[1]) ##1 (ctrl_word[12:10] == $past(ctrl_word[15:13]))
      |-> addr_out == $past(data_in)); // R8

  AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n || !seen[2])
    !ctrl_word[0] ##1 $stable(ctrl_word) && !ctrl_word[6]
      |-> $stable(addr_out) && $stable(data_out)); // R9
endmodule

bind cw_datapath cw_datapath_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctrl_word (ctrl_word),
  .const_in  (const_in),
  .data_in   (data_in),
  .addr_out  (addr_out),
  .data_out  (data_out),
  .flag_v    (flag_v),
  .flag_c    (flag_c),
  .flag_n    (flag_n),
  .flag_z    (flag_z)
);

// File: tb/cw_datapath_bench.sv
module cw_datapath_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] ctrl_word, const_in, data_in;
  logic [15:0] addr_out, data_out;
  logic        flag_v, flag_c, flag_n, flag_z;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] vals [8];

  always #2 clk = ~clk;

  cw_datapath u_cw_datapath (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .const_in(const_in),
    .data_in(data_in), .addr_out(addr_out), .data_out(data_out),
    .flag_v(flag_v), .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z)
  );

  // R1: field packing
  function automatic logic [15:0] cw(input int da, aa, ba, mb, fs, md, rw);
    return {3'(da), 3'(aa), 3'(ba), 1'(mb), 4'(fs), 1'(md), 1'(rw)};
  endfunction

  // expected {v,c,n,z,f}
  function automatic logic [19:0] model(input logic [15:0] a, b, input int fs);
    longint ua, uy, us;
    int sa, sy, ss, cin;
    logic [15:0] y, f;
    logic v, c;
    v = 0; c = 0;
    if (fs < 8) begin
      case (fs / 2)
        0: y = 16'h0000;
        1: y = b;
        2: y = ~b;
        default: y = 16'hFFFF;
      endcase
      cin = fs % 2;
      ua = longint'(a); uy = longint'(y);
      us = ua + uy + cin;
      f = us[15:0];
      c = (us >= 65536);
      sa = int'($signed(a)); sy = int'($signed(y));
      ss = sa + sy + cin;
      v = (ss > 32767) || (ss < -32768);
    end else begin
      case (fs)
        8:  f = a & b;
        9:  f = a | b;
        10: f = a ^ b;
        11: f = ~a;
        13: f = b / 2;
        14: f = 16'((b * 2) % 65536);
        default: f = b;
      endcase
    end
    return {v, c, f[15], f == 16'h0, f};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] w, input logic [15:0] k, input logic [15:0] d);
    @(negedge clk);
    ctrl_word = w; const_in = k; data_in = d;
    #1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    vals = '{16'h0000, 16'hFFFF, 16'h8000, 16'h7FFF, 16'h0001, 16'h5A5A, 16'hA5A5, 16'h1234};
    rst_n = 1'b0; ctrl_word = 16'h0; const_in = 16'h0; data_in = 16'h0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // R11: registers cleared after reset
    for (int r = 0; r < 8; r++) begin
      step(cw(0, r, r, 0, 0, 0, 0), 16'h0, 16'h0);
      chk("R11 reset A", addr_out, 16'h0);
      chk("R11 reset B", data_out, 16'h0);
    end
    // R8 R9: load via data_in, read back next cycle
    for (int r = 0; r < 8; r++) begin
      step(cw(r, 0, 0, 0, 0, 1, 1), 16'h0, vals[r]);
      step(cw(0, r, 0, 0, 0, 0, 0), 16'h0, 16'h0);
      chk("R8 ext write", addr_out, vals[r]);
    end
    // R2 R3 R4 R5 R6 R7: sweep all pairs and codes
    for (int aa = 0; aa < 8; aa++)
      for (int ba = 0; ba < 8; ba++)
        for (int fs = 0; fs < 16; fs++) begin
          logic [19:0] e;
          step(cw(0, aa, ba, 0, fs, 0, 0), 16'hDEAD, 16'h0);
          e = model(vals[aa], vals[ba], fs);
          chk("R2 addr_out", addr_out, vals[aa]);
          chk("R3 reg on B", data_out, vals[ba]);
          chk(fs < 8 ? "R4 arith" : (fs < 12 ? "R5 logic" : "R6 shift"),
              {flag_v, flag_c, flag_n, flag_z}, e[19:16]);
        end
    // R3 R7: constant on B
    for (int k = 0; k < 8; k++)
      for (int fs = 0; fs < 16; fs++) begin
        logic [19:0] e;
        step(cw(0, 5, 2, 1, fs, 0, 0), vals[k] ^ 16'h0F0F, 16'h0);
        e = model(vals[5], vals[k] ^ 16'h0F0F, fs);
        chk("R3 const on B", data_out, vals[k] ^ 16'h0F0F);
        chk("R7 flags const", {flag_v, flag_c, flag_n, flag_z}, e[19:16]);
      end
    // R8: function result written back, all codes, checked via A bus
    for (int fs = 0; fs < 16; fs++) begin
      logic [19:0] e;
      e = model(vals[7], vals[5], fs);
      step(cw(6, 7, 5, 0, fs, 0, 1), 16'h0, 16'hBEEF);
      step(cw(0, 6, 0, 0, 0, 0, 0), 16'h0, 16'h0);
      chk("R8 result write", addr_out, e[15:0]);
    end
    // R12: 0x2995 computes R1 <- R2 - R3
    step(16'h2995, 16'h0, 16'h0);
    step(cw(0, 1, 0, 0, 0, 0, 0), 16'h0, 16'h0);
    chk("R12 sub word", addr_out, 16'((vals[2] - vals[3]) % 65536));
    // R9: write disabled leaves registers unchanged
    step(cw(4, 4, 0, 0, 0, 1, 0), 16'h0, 16'h9999);
    step(cw(0, 4, 0, 0, 0, 0, 0), 16'h0, 16'h0);
    chk("R9 no write", addr_out, vals[4]);
    // R10: same-cycle read returns old value, new after edge
    step(cw(3, 3, 3, 0, 0, 1, 1), 16'h0, 16'h4321);
    chk("R10 old A", addr_out, vals[3]);
    chk("R10 old B", data_out, vals[3]);
    step(cw(0, 3, 0, 0, 0, 0, 0), 16'h0, 16'h0);
    chk("R10 new A", addr_out, 16'h4321);
    // R1: each field moved alone changes only its own effect
    step(cw(7, 0, 0, 0, 0, 1, 1), 16'h0, 16'h0C0C);
    step(cw(0, 7, 7, 0, 0, 0, 0), 16'h0, 16'h0);
    chk("R1 dst field", addr_out, 16'h0C0C);
    // R11: reset again clears written registers
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    for (int r = 0; r < 8; r++) begin
      step(cw(0, r, 0, 0, 0, 0, 0), 16'h0, 16'h0);
      chk("R11 re-reset", addr_out, 16'h0);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule